// File: doc/BRIEF.md
# Frame-synchronised control register bank

This block holds the 24-bit control words of a timing generator. A host writes a register through a parallel port that carries an 8-bit address, 24-bit data and a single-cycle write strobe. Five registers, at addresses 0x0A to 0x0E, are frame-synchronous. A write to one of them lands in a staging copy and becomes the active value only at the next falling edge of the frame input `vd_in`. That edge is seen through a two-flop synchroniser and an edge detector in the register clock domain. All pending staged values are committed on one cycle.

Three registers take effect at once. They are the clock setup word at 0xD5, the operating-role word at 0xD6, and the mode word at 0x01. Bit 0 of the mode word switches the five frame-synchronous registers to immediate update. Every active register is driven on its own output port. A combinational readback port returns the active value at any address.

Top module: `vd_shadow_regs`

## Requirements
- R1: After reset, register 0x0B reads 0x3007FF. This is a count of 0x7FF in bits [10:0] and enable bits 21 and 20 set. Every other register reads 0.
- R2: While bit 0 of 0x01 is 0, a write to 0x0A–0x0E leaves both its readback and its output port unchanged until a falling edge of `vd_in` follows the write.
- R3: When `vd_in` falls and then stays low for at least 3 clock cycles, every frame register that has a pending write shows its staged value on readback and on its output port.
- R4: If a frame register is written several times between two falling edges of `vd_in`, only the last value written is committed.
- R5: A write made after a falling edge of `vd_in` is not committed while `vd_in` stays low or stays high. It is committed at the next falling edge.
- R6: While bit 0 of 0x01 is 1, a write to 0x0A–0x0E is active in the cycle after the write strobe, with no `vd_in` edge.
- R7: Writes to 0x01 (bit 0), 0xD5 (bits [3:0]: [1:0] clock divider, 2 and 3 clock selectors) and 0xD6 (bit 0: 1 = slave role) are active in the cycle after the write strobe.
- R8: Only these bits can be written, and all other bits read as 0:
  - 0x0A: [22:0]
  - 0x0B: 21, 20, 16, [14:12] and [10:0], which is mask 0x3177FF
  - 0x0C: 20, 16, [14:12] and [10:0], which is mask 0x1177FF
  - 0x0D: 16 and [10:0]
  - 0x0E: [9:0]
- R9: An address outside the bank reads as 0. A write to it changes no register, even after a later `vd_in` edge.
- R10: Readback returns the active value, never the staged value. Each output port equals the readback of its register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 8 | Write address |
| wr_data | input | 24 | Write data |
| rd_addr | input | 8 | Readback address |
| rd_data | output | 24 | Active value at rd_addr, 0 if unmapped |
| vd_in | input | 1 | Frame timing input, asynchronous |
| frame_a | output | 24 | Active word 0x0A |
| frame_b | output | 24 | Active word 0x0B (subclock count and enables) |
| frame_c | output | 24 | Active word 0x0C (shutter control and positions) |
| frame_d | output | 24 | Active word 0x0D (substrate pulse polarity and line) |
| frame_e | output | 24 | Active word 0x0E |
| mode_word | output | 24 | Active word 0x01 (bit 0 = immediate update) |
| clock_word | output | 24 | Active word 0xD5 |
| role_word | output | 24 | Active word 0xD6 |

## Verification
Assertions check three rules on every cycle:
- A frame register holds its value on any cycle with no detected edge and no immediate write.
- An immediate write lands exactly one cycle later.
- Pending flags clear after a detected edge.

Scenarios show the behaviours that span many cycles:
- The latency from a real `vd_in` fall to visibility.
- Last-write-wins staging.
- No recommit while `vd_in` stays at one level.
- Writes to unmapped addresses leave every register untouched.

// File: rtl/vd_shadow_regs.sv
module vd_shadow_regs #(
  parameter int DW = 24,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          vd_in,
  output logic [DW-1:0] frame_a,
  output logic [DW-1:0] frame_b,
  output logic [DW-1:0] frame_c,
  output logic [DW-1:0] frame_d,
  output logic [DW-1:0] frame_e,
  output logic [DW-1:0] mode_word,
  output logic [DW-1:0] clock_word,
  output logic [DW-1:0] role_word
);
  localparam int NS = 5;
  localparam logic [AW-1:0] BASE   = AW'(8'h0A);
  localparam logic [AW-1:0] A_MODE = AW'(8'h01);
  localparam logic [AW-1:0] A_CLK  = AW'(8'hD5);
  localparam logic [AW-1:0] A_ROLE = AW'(8'hD6);
  localparam logic [DW-1:0] M_MODE = DW'(24'h000001);
  localparam logic [DW-1:0] M_CLK  = DW'(24'h00000F);
  localparam logic [DW-1:0] M_ROLE = DW'(24'h000001);

  function automatic logic [DW-1:0] smask(input int i);
    case (i)
      0:       smask = DW'(24'h7FFFFF);
      1:       smask = DW'(24'h3177FF);
      2:       smask = DW'(24'h1177FF);
      3:       smask = DW'(24'h0107FF);
      default: smask = DW'(24'h0003FF);
    endcase
  endfunction

  function automatic logic [DW-1:0] sinit(input int i);
    sinit = (i == 1) ? DW'(24'h3007FF) : '0;
  endfunction

  logic [DW-1:0] act [NS];
  logic [DW-1:0] stg [NS];
  logic [NS-1:0] pend, hit;
  logic [DW-1:0] mode_q, clk_q, role_q;
  logic [2:0]    vd_sync;
  logic          vd_fall, imm;

  assign vd_fall = vd_sync[2] & ~vd_sync[1];
  assign imm     = mode_q[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vd_sync <= '0;
    else        vd_sync <= {vd_sync[1:0], vd_in};

  for (genvar i = 0; i < NS; i++) begin : g_frame
    assign hit[i] = wr_en && (wr_addr == BASE + AW'(i));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        act[i]  <= sinit(i);
        stg[i]  <= sinit(i);
        pend[i] <= 1'b0;
      end else begin
        if (vd_fall && pend[i]) act[i] <= stg[i];
        if (hit[i]) begin
          stg[i] <= wr_data & smask(i);
          if (imm) begin
            act[i]  <= wr_data & smask(i);
            pend[i] <= 1'b0;
          end else begin
            pend[i] <= 1'b1;
          end
        end else if (vd_fall) begin
          pend[i] <= 1'b0;
        end
      end

    assert_hold_without_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!vd_fall && !(hit[i] && imm)) |=> $stable(act[i]));
    assert_immediate_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && imm) |=> act[i] == ($past(wr_data) & smask(i)));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= '0;
      clk_q  <= '0;
      role_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_MODE) mode_q <= wr_data & M_MODE;
      if (wr_addr == A_CLK)  clk_q  <= wr_data & M_CLK;
      if (wr_addr == A_ROLE) role_q <= wr_data & M_ROLE;
    end

  assert_pending_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_fall && !wr_en) |=> pend == '0);
  assert_clock_word_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CLK) |=> clk_q == ($past(wr_data) & M_CLK));

  always_comb begin
    rd_data = '0;
    if (rd_addr >= BASE && rd_addr < BASE + AW'(NS))
      rd_data = act[int'(rd_addr - BASE)];
    else if (rd_addr == A_MODE) rd_data = mode_q;
    else if (rd_addr == A_CLK)  rd_data = clk_q;
    else if (rd_addr == A_ROLE) rd_data = role_q;
  end

  assign frame_a    = act[0];
  assign frame_b    = act[1];
  assign frame_c    = act[2];
  assign frame_d    = act[3];
  assign frame_e    = act[4];
  assign mode_word  = mode_q;
  assign clock_word = clk_q;
  assign role_word  = role_q;
endmodule

// File: tb/tb_vd_shadow_regs.sv
`timescale 1ns/1ps
module tb_vd_shadow_regs;
  logic clk = 0, rst_n = 0, wr_en = 0, vd_in = 1;
  logic [7:0] wr_addr = 0, rd_addr = 0;
  logic [23:0] wr_data = 0;
  logic [23:0] rd_data, frame_a, frame_b, frame_c, frame_d, frame_e;
  logic [23:0] mode_word, clock_word, role_word;
  int checks = 0, errors = 0;
  logic [23:0] exp [8];

  vd_shadow_regs dut (.*);

  always #2.5 clk = ~clk;

  function automatic logic [7:0] addr_of(int k);
    case (k)
      0: return 8'h0A; 1: return 8'h0B; 2: return 8'h0C; 3: return 8'h0D;
      4: return 8'h0E; 5: return 8'h01; 6: return 8'hD5; default: return 8'hD6;
    endcase
  endfunction

  function automatic logic [23:0] mask_of(int k);
    case (k)
      0: return 24'h7FFFFF; 1: return 24'h3177FF; 2: return 24'h1177FF;
      3: return 24'h0107FF; 4: return 24'h0003FF; 5: return 24'h000001;
      6: return 24'h00000F; default: return 24'h000001;
    endcase
  endfunction

  function automatic logic [23:0] port_of(int k);
    case (k)
      0: return frame_a; 1: return frame_b; 2: return frame_c; 3: return frame_d;
      4: return frame_e; 5: return mode_word; 6: return clock_word; default: return role_word;
    endcase
  endfunction

  function automatic bit mapped(logic [7:0] a);
    for (int k = 0; k < 8; k++) if (addr_of(k) == a) return 1;
    return 0;
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] want);
    checks++;
    if (act !== want) begin
      errors++;
      $display("FAIL %s actual %06h expected %06h", req, act, want);
    end
  endtask

  task automatic check_reg(string req, int k);
    rd_addr = addr_of(k);
    #0.5;
    check(req, rd_data, exp[k]);
    check("R10", port_of(k), exp[k]);
  endtask

  task automatic check_all(string req);
    for (int k = 0; k < 8; k++) check_reg(req, k);
  endtask

  task automatic write(logic [7:0] a, logic [23:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic vd_edge();
    @(negedge clk); vd_in = 1;
    repeat (4) @(negedge clk);
    vd_in = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) exp[k] = 24'h0;
    exp[1] = 24'h3007FF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1");

    for (int a = 0; a < 256; a++)
      if (!mapped(8'(a))) begin
        rd_addr = 8'(a); #0.5;
        check("R9", rd_data, 24'h0);
      end

    for (int k = 0; k < 5; k++) begin
      write(addr_of(k), 24'hFFFFFF);
      check_reg("R2", k);
      write(addr_of(k), 24'h000000);
      write(addr_of(k), 24'hFFFFFF);
    end
    check_all("R2");
    vd_edge();
    for (int k = 0; k < 5; k++) exp[k] = mask_of(k);
    check_all("R8");

    for (int k = 0; k < 5; k++) begin
      write(addr_of(k), 24'h123456 ^ 24'(k));
      write(addr_of(k), 24'hA5A5A5 ^ (24'h111111 * 24'(k)));
    end
    check_all("R2");
    vd_edge();
    for (int k = 0; k < 5; k++) exp[k] = (24'hA5A5A5 ^ (24'h111111 * 24'(k))) & mask_of(k);
    check_all("R4");
    check_all("R3");

    write(8'h0D, 24'h010123);
    repeat (6) @(negedge clk);
    check_reg("R5", 3);
    vd_in = 1;
    repeat (6) @(negedge clk);
    check_reg("R5", 3);
    vd_in = 0;
    repeat (4) @(negedge clk);
    exp[3] = 24'h010123;
    check_reg("R5", 3);

    for (int a = 0; a < 256; a++)
      if (!mapped(8'(a))) write(8'(a), 24'hFFFFFF);
    vd_edge();
    check_all("R9");

    write(8'hD5, 24'hFFFFFF); exp[6] = 24'h00000F; check_reg("R7", 6);
    write(8'hD5, 24'hFFFFF2); exp[6] = 24'h000002; check_reg("R7", 6);
    write(8'hD6, 24'hFFFFFF); exp[7] = 24'h000001; check_reg("R7", 7);
    write(8'h01, 24'h000001); exp[5] = 24'h000001; check_reg("R7", 5);

    for (int k = 0; k < 5; k++) begin
      write(addr_of(k), 24'hABCDEF + 24'(k));
      exp[k] = (24'hABCDEF + 24'(k)) & mask_of(k);
      check_reg("R6", k);
    end

    write(8'h01, 24'h000000); exp[5] = 24'h0;
    write(8'h0C, 24'h000000);
    check_reg("R2", 2);
    vd_edge();
    exp[2] = 24'h0;
    check_reg("R3", 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule